// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block runs the command protocol of a 32-bit parallel NOR flash port made of two 16-bit devices side by side. A client hands it one operation at a time (word program, sector erase, sector lock, sector unlock or lock-status query), along with a word address and a data word. The sequencer issues the command writes the operation needs and polls the status word until both devices report ready. It supervises the poll with a cycle-count timeout, runs the matching recovery writes, and leaves the port in read-array mode. It then reports a 2-bit result code on a one-cycle done pulse.

The request side is a valid/ready stream. `req_ready` is high only while the sequencer is idle. A client holds `req_valid` and the request fields steady until a cycle in which `req_valid` and `req_ready` are both high. The fields are captured in that cycle. The result side has no back-pressure: `done` lasts exactly one cycle, and `result` and `locked` are valid in that cycle. Every bus access holds its strobe for `WAIT` cycles and is followed by at least one idle cycle.

Every command code is placed in the low byte of both 16-bit halves, so command X goes out as 0x00XX00XX. Sector base addresses are the word address with its low `SECT_W` bits cleared.

Top module: `nor_cmd_seq`

## Requirements
- R1: Every command write carries its code replicated in both halves (0x00XX00XX). The program data word is the only write that is not replicated.
- R2: A program first reads the target word. If (current & new) differs from new, the sequencer makes no write and finishes with result 2.
- R3: A program that passes the check writes 0x00400040 and then the data to the target address, polls that address until ready, and writes 0x00FF00FF there. It then finishes with result 0.
- R4: If a program poll is still not ready once PRG_TO cycles have passed in the poll, the sequencer writes 0x00FF00FF and finishes with result 1.
- R5: An erase writes 0x00500050, 0x00200020 and 0x00D000D0 to the sector base and polls there. When ready, it writes 0x00500050 and then 0x00FF00FF, and finishes with result 0.
- R6: On an erase poll timeout (ERS_TO cycles), the writes that follow are 0x00B000B0, 0x00FF00FF, 0x00500050 and 0x00FF00FF, in that order. The result is 1.
- R7: A lock writes 0x00500050, 0x00600060 and 0x00010001 to the sector base. An unlock uses the same sequence with 0x00D000D0 as the last write. After ready, result 0 requires a status word of exactly 0x00800080; any other ready status gives result 3. Either way the sequence ends with 0x00FF00FF.
- R8: A lock or unlock poll that exceeds LCK_TO cycles writes 0x00FF00FF and finishes with result 1.
- R9: A query writes 0x00700070 to the sector base and polls for ready. It then writes 0x00900090, reads the word at sector base + 2, and reports locked = 1 if bit 0 or bit 16 is set. It ends with a write of 0x00FF00FF and result 0.
- R10: A query whose status wait exceeds ERS_TO cycles writes 0x00FF00FF and finishes with result 1 and locked = 1.
- R11: req_ready is high only when idle, and done is a single-cycle pulse. An operation code outside 0..4 (0 program, 1 erase, 2 lock, 3 unlock, 4 query) makes no bus access and finishes with result 3.
- R12: Ready means bit 7 is set in both halves (mask 0x00800080). A status word with only one half ready keeps the sequencer polling.
- R13: Each access holds exactly one strobe low for WAIT cycles. Both strobes are high in at least the cycle after a strobe ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request accepted this cycle if valid |
| req_op | input | 3 | Operation code (0 program, 1 erase, 2 lock, 3 unlock, 4 query) |
| req_addr | input | AW | Word address |
| req_data | input | 32 | Program data |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | 0 ok, 1 timeout, 2 not erased, 3 status error |
| locked | output | 1 | Lock flag from a query, valid with done |
| fl_addr | output | AW | Flash word address |
| fl_wdata | output | 32 | Flash write data |
| fl_rdata | input | 32 | Flash read data |
| fl_wr_n | output | 1 | Write strobe, active low |
| fl_rd_n | output | 1 | Read strobe, active low |

## Verification
Some properties are checked on every cycle: strobe exclusivity and the idle cycle after each access, replication of every command byte, the single-cycle done pulse, and ready falling once a request is taken. Result codes are also checked against their operations: not-erased only for programs, a timed-out query always reported as locked, and the timer cleared on entry to each poll. Only the scenarios with the bench's flash model can show the exact order and addresses of the command writes for each operation and recovery path. The same holds for the decision between ready and timeout when only one half reports ready, and for the lock flag being taken from offset 2.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

  localparam logic [2:0] OP_PROG   = 3'd0;
  localparam logic [2:0] OP_ERASE  = 3'd1;
  localparam logic [2:0] OP_LOCK   = 3'd2;
  localparam logic [2:0] OP_UNLOCK = 3'd3;
  localparam logic [2:0] OP_QUERY  = 3'd4;

  localparam logic [1:0] RES_OK      = 2'd0;
  localparam logic [1:0] RES_TIMEOUT = 2'd1;
  localparam logic [1:0] RES_DIRTY   = 2'd2;
  localparam logic [1:0] RES_STATUS  = 2'd3;

  localparam logic [7:0] C_PROG_SETUP = 8'h40;
  localparam logic [7:0] C_CLR_STAT   = 8'h50;
  localparam logic [7:0] C_ERS_SETUP  = 8'h20;
  localparam logic [7:0] C_CONFIRM    = 8'hD0;
  localparam logic [7:0] C_SUSPEND    = 8'hB0;
  localparam logic [7:0] C_READ_ARR   = 8'hFF;
  localparam logic [7:0] C_LOCK_SETUP = 8'h60;
  localparam logic [7:0] C_LOCK_SET   = 8'h01;
  localparam logic [7:0] C_RD_STAT    = 8'h70;
  localparam logic [7:0] C_RD_ID      = 8'h90;

  localparam logic [31:0] READY_MASK = 32'h0080_0080;
  localparam logic [31:0] CLEAN_STAT = 32'h0080_0080;
  localparam logic [31:0] LOCK_MASK  = 32'h0001_0001;

  typedef enum logic [1:0] {B_IDLE, B_STRB, B_GAP} bus_st_e;

  typedef enum logic [4:0] {
    ST_IDLE, ST_PCHK, ST_P_SETUP, ST_P_DATA, ST_P_POLL,
    ST_E_CLR, ST_E_SETUP, ST_E_CONF, ST_E_POLL, ST_E_SUSP, ST_E_RA, ST_E_CLR2,
    ST_L_CLR, ST_L_SETUP, ST_L_ARG, ST_L_POLL,
    ST_Q_STAT, ST_Q_POLL, ST_Q_ID, ST_Q_READ,
    ST_FIN, ST_DONE
  } seq_st_e;

  function automatic logic [31:0] rep(input logic [7:0] c);
    return {8'h00, c, 8'h00, c};
  endfunction

endpackage

// File: rtl/nor_bus_engine.sv
module nor_bus_engine
  import nor_seq_pkg::*;
#(
  parameter int AW   = 24,
  parameter int WAIT = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wdata,
  output logic          idle,
  output logic          ack,
  output logic [31:0]   rdata,
  output logic [AW-1:0] fl_addr,
  output logic [31:0]   fl_wdata,
  input  logic [31:0]   fl_rdata,
  output logic          fl_wr_n,
  output logic          fl_rd_n
);
  localparam int CNTW = (WAIT > 1) ? $clog2(WAIT) : 1;
  localparam logic [CNTW-1:0] CNT_LOAD = CNTW'(WAIT - 1);

  bus_st_e         st;
  logic [CNTW-1:0] cnt;
  logic            wr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= B_IDLE;
      cnt      <= '0;
      wr_q     <= 1'b0;
      fl_addr  <= '0;
      fl_wdata <= '0;
      rdata    <= '0;
    end else begin
      case (st)
        B_IDLE: if (start) begin
          st       <= B_STRB;
          cnt      <= CNT_LOAD;
          wr_q     <= wr;
          fl_addr  <= addr;
          fl_wdata <= wdata;
        end
        B_STRB: begin
          if (cnt == '0) begin
            st <= B_GAP;
            if (!wr_q) rdata <= fl_rdata;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: st <= B_IDLE;
      endcase
    end
  end

  assign idle    = (st == B_IDLE);
  assign ack     = (st == B_GAP);
  assign fl_wr_n = !((st == B_STRB) && wr_q);
  assign fl_rd_n = !((st == B_STRB) && !wr_q);

  assert_strobe_excl_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !(!fl_wr_n && !fl_rd_n));
  assert_gap_wr_R13: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fl_wr_n) |=> (fl_wr_n && fl_rd_n));
  assert_gap_rd_R13: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fl_rd_n) |=> (fl_wr_n && fl_rd_n));
  assert_addr_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (!fl_wr_n && $past(!fl_wr_n)) |-> $stable(fl_addr) && $stable(fl_wdata));

endmodule

// File: rtl/nor_op_timer.sv
module nor_op_timer #(
  parameter int CW = 21
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic [CW-1:0] limit,
  output logic          expired
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (clear)         cnt <= '0;
    else if (cnt != '1)     cnt <= cnt + 1'b1;
  end

  assign expired = (cnt >= limit);

  assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (clear && limit != '0 && $stable(limit)) |=> !expired || limit != $past(limit));

endmodule

// File: rtl/nor_status_eval.sv
module nor_status_eval
  import nor_seq_pkg::*;
(
  input  logic [31:0] word,
  input  logic [31:0] newdata,
  output logic        ready,
  output logic        clean,
  output logic        lock_bit,
  output logic        erased_ok
);
  assign ready     = ((word & READY_MASK) == READY_MASK);
  assign clean     = (word == CLEAN_STAT);
  assign lock_bit  = |(word & LOCK_MASK);
  assign erased_ok = ((word & newdata) == newdata);
endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
  import nor_seq_pkg::*;
#(
  parameter int AW     = 24,
  parameter int SECT_W = 15,
  parameter int WAIT   = 2,
  parameter int PRG_TO = 4096,
  parameter int ERS_TO = 1048576,
  parameter int LCK_TO = 65536
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [2:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [31:0]   req_data,
  output logic          done,
  output logic [1:0]    result,
  output logic          locked,
  output logic [AW-1:0] fl_addr,
  output logic [31:0]   fl_wdata,
  input  logic [31:0]   fl_rdata,
  output logic          fl_wr_n,
  output logic          fl_rd_n
);
  localparam int MAX_TO = (PRG_TO > ERS_TO) ? ((PRG_TO > LCK_TO) ? PRG_TO : LCK_TO)
                                            : ((ERS_TO > LCK_TO) ? ERS_TO : LCK_TO);
  localparam int CW = $clog2(MAX_TO + 2);
  localparam logic [AW-1:0] BASE_MASK = ~((AW'(1) << SECT_W) - AW'(1));

  seq_st_e       st;
  logic [2:0]    op_q;
  logic [AW-1:0] addr_q;
  logic [31:0]   data_q;
  logic [1:0]    res_q;
  logic          lock_q;
  logic [CW-1:0] limit_q;
  logic [AW-1:0] base;

  logic          acc_on, acc_wr, acc_poll;
  logic [AW-1:0] acc_addr;
  logic [31:0]   acc_wdata;
  logic          bus_idle, bus_ack, acc_start;
  logic [31:0]   bus_rdata;
  logic          s_ready, s_clean, s_lock, s_erased, t_expired;

  assign base = addr_q & BASE_MASK;

  always_comb begin
    acc_on    = 1'b1;
    acc_wr    = 1'b1;
    acc_poll  = 1'b0;
    acc_addr  = base;
    acc_wdata = rep(C_READ_ARR);
    case (st)
      ST_PCHK:    begin acc_wr = 1'b0; acc_addr = addr_q; end
      ST_P_SETUP: begin acc_addr = addr_q; acc_wdata = rep(C_PROG_SETUP); end
      ST_P_DATA:  begin acc_addr = addr_q; acc_wdata = data_q; end
      ST_P_POLL:  begin acc_wr = 1'b0; acc_poll = 1'b1; acc_addr = addr_q; end
      ST_E_CLR, ST_E_CLR2, ST_L_CLR: acc_wdata = rep(C_CLR_STAT);
      ST_E_SETUP: acc_wdata = rep(C_ERS_SETUP);
      ST_E_CONF:  acc_wdata = rep(C_CONFIRM);
      ST_E_SUSP:  acc_wdata = rep(C_SUSPEND);
      ST_E_RA:    acc_wdata = rep(C_READ_ARR);
      ST_L_SETUP: acc_wdata = rep(C_LOCK_SETUP);
      ST_L_ARG:   acc_wdata = (op_q == OP_LOCK) ? rep(C_LOCK_SET) : rep(C_CONFIRM);
      ST_Q_STAT:  acc_wdata = rep(C_RD_STAT);
      ST_Q_ID:    acc_wdata = rep(C_RD_ID);
      ST_E_POLL, ST_L_POLL, ST_Q_POLL: begin acc_wr = 1'b0; acc_poll = 1'b1; end
      ST_Q_READ:  begin acc_wr = 1'b0; acc_addr = base + AW'(2); end
      ST_FIN:     acc_addr = (op_q == OP_PROG) ? addr_q : base;
      default:    acc_on = 1'b0;
    endcase
  end

  assign acc_start = acc_on && bus_idle;

  nor_bus_engine #(.AW(AW), .WAIT(WAIT)) u_bus (
    .clk(clk), .rst_n(rst_n), .start(acc_start), .wr(acc_wr), .addr(acc_addr),
    .wdata(acc_wdata), .idle(bus_idle), .ack(bus_ack), .rdata(bus_rdata),
    .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_rdata(fl_rdata),
    .fl_wr_n(fl_wr_n), .fl_rd_n(fl_rd_n)
  );

  nor_op_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .clear(!acc_poll), .limit(limit_q), .expired(t_expired)
  );

  nor_status_eval u_eval (
    .word(bus_rdata), .newdata(data_q), .ready(s_ready), .clean(s_clean),
    .lock_bit(s_lock), .erased_ok(s_erased)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      op_q    <= OP_PROG;
      addr_q  <= '0;
      data_q  <= '0;
      res_q   <= RES_OK;
      lock_q  <= 1'b0;
      limit_q <= '0;
    end else begin
      case (st)
        ST_IDLE: if (req_valid) begin
          op_q   <= req_op;
          addr_q <= req_addr;
          data_q <= req_data;
          res_q  <= RES_OK;
          lock_q <= 1'b0;
          case (req_op)
            OP_PROG:   begin st <= ST_PCHK;   limit_q <= CW'(PRG_TO); end
            OP_ERASE:  begin st <= ST_E_CLR;  limit_q <= CW'(ERS_TO); end
            OP_LOCK, OP_UNLOCK:
                       begin st <= ST_L_CLR;  limit_q <= CW'(LCK_TO); end
            OP_QUERY:  begin st <= ST_Q_STAT; limit_q <= CW'(ERS_TO); end
            default:   begin st <= ST_DONE;   res_q <= RES_STATUS; end
          endcase
        end
        ST_DONE: st <= ST_IDLE;
        default: if (bus_ack) begin
          case (st)
            ST_PCHK: if (s_erased) st <= ST_P_SETUP;
                     else begin res_q <= RES_DIRTY; st <= ST_DONE; end
            ST_P_SETUP: st <= ST_P_DATA;
            ST_P_DATA:  st <= ST_P_POLL;
            ST_P_POLL: if (s_ready) st <= ST_FIN;
                       else if (t_expired) begin res_q <= RES_TIMEOUT; st <= ST_FIN; end
            ST_E_CLR:   st <= ST_E_SETUP;
            ST_E_SETUP: st <= ST_E_CONF;
            ST_E_CONF:  st <= ST_E_POLL;
            ST_E_POLL: if (s_ready) st <= ST_E_CLR2;
                       else if (t_expired) begin res_q <= RES_TIMEOUT; st <= ST_E_SUSP; end
            ST_E_SUSP:  st <= ST_E_RA;
            ST_E_RA:    st <= ST_E_CLR2;
            ST_E_CLR2:  st <= ST_FIN;
            ST_L_CLR:   st <= ST_L_SETUP;
            ST_L_SETUP: st <= ST_L_ARG;
            ST_L_ARG:   st <= ST_L_POLL;
            ST_L_POLL: if (s_ready) begin
                         res_q <= s_clean ? RES_OK : RES_STATUS;
                         st <= ST_FIN;
                       end else if (t_expired) begin res_q <= RES_TIMEOUT; st <= ST_FIN; end
            ST_Q_STAT:  st <= ST_Q_POLL;
            ST_Q_POLL: if (s_ready) st <= ST_Q_ID;
                       else if (t_expired) begin
                         res_q <= RES_TIMEOUT; lock_q <= 1'b1; st <= ST_FIN;
                       end
            ST_Q_ID:    st <= ST_Q_READ;
            ST_Q_READ:  begin lock_q <= s_lock; st <= ST_FIN; end
            ST_FIN:     st <= ST_DONE;
            default:    st <= ST_IDLE;
          endcase
        end
      endcase
    end
  end

  assign req_ready = (st == ST_IDLE);
  assign done      = (st == ST_DONE);
  assign result    = res_q;
  assign locked    = lock_q;

  assert_cmd_rep_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!fl_wr_n && st != ST_P_POLL && op_q != OP_PROG) |-> fl_wdata[31:16] == fl_wdata[15:0]);
  assert_dirty_prog_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && result == RES_DIRTY) |-> op_q == OP_PROG);
  assert_status_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && result == RES_STATUS) |-> (op_q == OP_LOCK || op_q == OP_UNLOCK || op_q > OP_QUERY));
  assert_query_to_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_q == OP_QUERY && result == RES_TIMEOUT) |-> locked);
  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  assert_idle_bus_R11: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (fl_wr_n && fl_rd_n));

endmodule

// File: tb/tb_nor_cmd_seq.sv
module tb_nor_cmd_seq;
  localparam int AW = 24;
  localparam int WAIT = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [2:0] req_op = '0;
  logic [AW-1:0] req_addr = '0;
  logic [31:0] req_data = '0;
  logic done, locked;
  logic [1:0] result;
  logic [AW-1:0] fl_addr;
  logic [31:0] fl_wdata, fl_rdata;
  logic fl_wr_n, fl_rd_n;

  always #2 clk = ~clk;

  nor_cmd_seq #(.AW(AW), .SECT_W(15), .WAIT(WAIT), .PRG_TO(64), .ERS_TO(96), .LCK_TO(80)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_addr(req_addr), .req_data(req_data), .done(done), .result(result), .locked(locked),
    .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_rdata(fl_rdata),
    .fl_wr_n(fl_wr_n), .fl_rd_n(fl_rd_n)
  );

  int tests = 0, fails = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // flash model
  logic [31:0] mem [16];
  int busy = 0, busy_cfg = 3;
  logic [31:0] status_val = 32'h0080_0080;
  logic lockbit = 1'b0;
  int mode = 0;
  bit prog_pend = 0;
  logic [AW-1:0] last_id_addr = '0;

  assign fl_rdata = (mode == 0) ? mem[fl_addr[3:0]] :
                    (mode == 1) ? ((busy > 0) ? 32'h0080_0000 : status_val) :
                    ((fl_addr[1:0] == 2'd2) ? {31'b0, lockbit} : 32'b0);

  // scoreboard queues
  logic [AW+31:0] exp_wr[$];
  logic [2:0] exp_res[$];
  string cur_tag = "";
  bit wr_prev = 1, rd_prev = 1;
  int low_cnt = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!fl_wr_n && wr_prev) begin
        if (exp_wr.size() == 0) chk(0, {cur_tag, " unexpected write"}, {8'h0, fl_addr, fl_wdata}, 64'h0);
        else begin
          logic [AW+31:0] e;
          e = exp_wr.pop_front();
          chk(e == {fl_addr, fl_wdata}, {cur_tag, " write"}, {8'h0, fl_addr, fl_wdata}, {8'h0, e});
        end
        if (prog_pend) begin
          mem[fl_addr[3:0]] = fl_wdata; prog_pend = 0; mode = 1; busy = busy_cfg;
        end else if (fl_wdata == 32'h00FF_00FF) mode = 0;
        else if (fl_wdata == 32'h0090_0090) mode = 2;
        else begin
          if (fl_wdata == 32'h0040_0040) prog_pend = 1;
          mode = 1; busy = busy_cfg;
        end
      end
      if (!fl_rd_n && rd_prev) begin
        if (mode == 1 && busy > 0) busy--;
        if (mode == 2) last_id_addr = fl_addr;
      end
      if (!fl_wr_n || !fl_rd_n) low_cnt++;
      else if (low_cnt != 0) begin
        chk(low_cnt == WAIT, "R13 strobe width", low_cnt, WAIT);
        low_cnt = 0;
      end
      if (done) begin
        if (exp_res.size() == 0) chk(0, {cur_tag, " unexpected done"}, {result, locked}, 0);
        else begin
          logic [2:0] r;
          r = exp_res.pop_front();
          chk(r == {locked, result}, {cur_tag, " result"}, {locked, result}, r);
        end
      end
    end
    wr_prev = fl_wr_n;
    rd_prev = fl_rd_n;
  end

  task automatic pw(input logic [AW-1:0] a, input logic [7:0] c);
    exp_wr.push_back({a, 8'h00, c, 8'h00, c});
  endtask

  task automatic run(input string tag, input logic [2:0] op, input logic [AW-1:0] a,
                     input logic [31:0] d, input logic [1:0] res, input logic lk);
    cur_tag = tag;
    exp_res.push_back({lk, res});
    @(negedge clk);
    req_valid = 1; req_op = op; req_addr = a; req_data = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    chk(!req_ready || done, "R11 ready low while busy", req_ready, 0);
    while (exp_res.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(exp_wr.size() == 0, {tag, " all writes seen"}, exp_wr.size(), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 32'hFFFF_FFFF;
    mem[6] = 32'h0000_FFFF;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready && !done && fl_wr_n && fl_rd_n, "reset state",
        {req_ready, done, fl_wr_n, fl_rd_n}, 4'b1011);

    // R3 program ok
    busy_cfg = 3;
    pw(24'h000105, 8'h40); exp_wr.push_back({24'h000105, 32'h1234_5678}); pw(24'h000105, 8'hFF);
    run("R3 program", 3'd0, 24'h000105, 32'h1234_5678, 2'd0, 1'b0);
    chk(mem[5] == 32'h1234_5678, "R3 data landed", mem[5], 32'h1234_5678);

    // R2 not erased
    run("R2 dirty", 3'd0, 24'h000106, 32'h00FF_00FF, 2'd2, 1'b0);

    // R4 / R12 program timeout with only one half ready
    busy_cfg = 100000;
    pw(24'h000107, 8'h40); exp_wr.push_back({24'h000107, 32'hA5A5_0000}); pw(24'h000107, 8'hFF);
    run("R4 R12 program timeout", 3'd0, 24'h000107, 32'hA5A5_0000, 2'd1, 1'b0);

    // R5 erase ok at sector base
    busy_cfg = 5;
    pw(24'h010000, 8'h50); pw(24'h010000, 8'h20); pw(24'h010000, 8'hD0);
    pw(24'h010000, 8'h50); pw(24'h010000, 8'hFF);
    run("R5 erase", 3'd1, 24'h012345, 32'h0, 2'd0, 1'b0);

    // R6 erase timeout
    busy_cfg = 100000;
    pw(24'h010000, 8'h50); pw(24'h010000, 8'h20); pw(24'h010000, 8'hD0);
    pw(24'h010000, 8'hB0); pw(24'h010000, 8'hFF); pw(24'h010000, 8'h50); pw(24'h010000, 8'hFF);
    run("R6 erase timeout", 3'd1, 24'h012345, 32'h0, 2'd1, 1'b0);

    // R7 lock ok, unlock with status error
    busy_cfg = 2;
    pw(24'h028000, 8'h50); pw(24'h028000, 8'h60); pw(24'h028000, 8'h01); pw(24'h028000, 8'hFF);
    run("R7 lock", 3'd2, 24'h02ABCD, 32'h0, 2'd0, 1'b0);
    status_val = 32'h0080_0090;
    pw(24'h028000, 8'h50); pw(24'h028000, 8'h60); pw(24'h028000, 8'hD0); pw(24'h028000, 8'hFF);
    run("R7 unlock status error", 3'd3, 24'h02ABCD, 32'h0, 2'd3, 1'b0);
    status_val = 32'h0080_0080;

    // R8 lock timeout
    busy_cfg = 100000;
    pw(24'h028000, 8'h50); pw(24'h028000, 8'h60); pw(24'h028000, 8'h01); pw(24'h028000, 8'hFF);
    run("R8 lock timeout", 3'd2, 24'h02ABCD, 32'h0, 2'd1, 1'b0);

    // R9 query locked / unlocked
    busy_cfg = 2; lockbit = 1;
    pw(24'h038000, 8'h70); pw(24'h038000, 8'h90); pw(24'h038000, 8'hFF);
    run("R9 query locked", 3'd4, 24'h03F001, 32'h0, 2'd0, 1'b1);
    chk(last_id_addr == 24'h038002, "R9 id offset", last_id_addr, 24'h038002);
    lockbit = 0;
    pw(24'h038000, 8'h70); pw(24'h038000, 8'h90); pw(24'h038000, 8'hFF);
    run("R9 query unlocked", 3'd4, 24'h03F001, 32'h0, 2'd0, 1'b0);

    // R10 query timeout
    busy_cfg = 100000;
    pw(24'h038000, 8'h70); pw(24'h038000, 8'hFF);
    run("R10 query timeout", 3'd4, 24'h03F001, 32'h0, 2'd1, 1'b1);

    // R11 unknown op
    run("R11 bad op", 3'd6, 24'h000001, 32'h0, 2'd3, 1'b0);
    chk(req_ready, "R11 idle after op", req_ready, 1);

    // R1 replication is covered by every command write compared above
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule